// File: doc/BRIEF.md
# Autonomous Fuse Word Reader

This block fetches one 32-bit word out of a 128-byte one-time-programmable fuse array after a single register write, without software clocking the fuse array bit by bit. Software writes a command register carrying an enable bit, a read bit and a word index. The block then runs a self-timed fetch of a fixed, parameterised number of clock cycles. When the fetch ends, the word lands in a read-only result register and a completion flag is raised. That flag drives an interrupt line, and software drops it by writing a one to it.

The array is split into a protected lower part of 96 bytes (words 0 to 23) and an open upper part of 32 bytes (words 24 to 31). Whether a request is privileged is sampled from `req_secure` when the command is accepted. An unprivileged request for a protected word completes normally but returns zero. A command written while a fetch is running is dropped. The fuse contents come in on a flat input that stands in for the sensed fuse cells.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After reset, the status register (offset 0x18), the result register (0x20) and the command register (0x24) all read zero, and `irq` is low.
- R2: A write to 0x24 while idle with bit 0 (enable) and bit 1 (read) both set starts a fetch. Status bit 1 (busy) reads one for exactly FETCH_CYCLES consecutive cycles, beginning in the cycle after the write.
- R3: A write to 0x24 with only one of bit 0 and bit 1 set stores the written fields (bits 1:0 and the word index in bits 25:16) but starts no fetch: busy stays low and the completion flag stays low.
- R4: On the clock edge where busy falls, several things happen together. The result register takes array word w, which is `fuse_image[32*w+31:32*w]` for the index w in bits 25:16. Status bit 0 (finish) is set. Command bits 1:0 clear, and the index field is kept.
- R5: Words 0 to 23 are protected. A request made with `req_secure` low gets zero for those words and real data for words 24 to 31. A request made with `req_secure` high gets real data for every word from 0 to 31. The finish flag is set in every one of these cases.
- R6: A word index of 32 or more returns zero and still sets finish.
- R7: Writing 0x18 with bit 0 set clears finish, and writing it with bit 0 clear leaves finish unchanged. If the clear and a fetch completion land on the same edge, finish ends set.
- R8: A write to 0x24 while busy is ignored. The command register keeps its value, and no second fetch follows.
- R9: `irq` equals the finish flag at all times.
- R10: Every fetch ends within 4 µs at CLK_MHZ. Busy never stays high for longer than FETCH_CYCLES cycles, and FETCH_CYCLES must not exceed 4*CLK_MHZ.
- R11: A read of any offset other than 0x18, 0x20 and 0x24 returns zero. A write to 0x20 leaves the result register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| req_secure | input | 1 | Requester is privileged; sampled when a command starts |
| fuse_image | input | 1024 | Sensed fuse array contents, byte 0 in bits 7:0 |
| irq | output | 1 | Completion interrupt, high while finish is set |

## Verification
The bound checker watches a set of cycle-level relations on every cycle:
- busy falls exactly when the completion pulse ends, and the command bits clear on that same edge;
- finish only ever rises out of a completion;
- a clear that does not coincide with a completion drops finish;
- the command register holds still under writes made while busy;
- an unprivileged fetch of a protected word leaves zero in the result;
- the running busy count never passes the fetch length or the 4 µs limit.

Other behaviour can only be shown by the bench's scenarios, because the expected values depend on stimulus the checker cannot see. The bench checks:
- which fuse word actually arrives, for random indices and privilege levels, against its own model of the array;
- the exact busy duration;
- the same-edge set/clear race;
- half-formed commands that start nothing;
- reads of unmapped offsets.

// File: rtl/fuse_ar_pkg.sv
package fuse_ar_pkg;
  localparam int ARRAY_BYTES  = 128;
  localparam int SECURE_BYTES = 96;
  localparam int WORD_BYTES   = 4;
  localparam int WORD_W       = WORD_BYTES * 8;
  localparam int NUM_WORDS    = ARRAY_BYTES / WORD_BYTES;
  localparam int SECURE_WORDS = SECURE_BYTES / WORD_BYTES;
  localparam int IMG_W        = ARRAY_BYTES * 8;
  localparam int IDX_W        = 10;
  localparam int IDX_LSB      = 16;
  localparam int WSEL_W       = $clog2(NUM_WORDS);

  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_RESULT = 8'h20;
  localparam logic [7:0] OFS_CMD    = 8'h24;

  localparam int BIT_EN   = 0;
  localparam int BIT_RD   = 1;
  localparam int BIT_FIN  = 0;
  localparam int BIT_BUSY = 1;

  // Bits of the command register that hold state.
  function automatic logic [31:0] cmd_mask();
    logic [31:0] m;
    m = '0;
    m[BIT_EN] = 1'b1;
    m[BIT_RD] = 1'b1;
    m[IDX_LSB +: IDX_W] = '1;
    return m;
  endfunction

  // True when the requester may see the word at this index.
  function automatic logic word_visible(input logic [IDX_W-1:0] idx, input logic priv);
    if (idx >= IDX_W'(NUM_WORDS)) return 1'b0;
    if (!priv && (idx < IDX_W'(SECURE_WORDS))) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic is_launch(input logic [31:0] wdata);
    return wdata[BIT_EN] & wdata[BIT_RD];
  endfunction
endpackage

// File: rtl/fuse_ar_seq.sv
module fuse_ar_seq #(
  parameter int FETCH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(FETCH_CYCLES + 1);

  logic [CW-1:0] remain_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (busy_q) begin
      if (remain_q == '0) busy_q <= 1'b0;
      else remain_q <= remain_q - 1'b1;
    end else if (launch) begin
      busy_q   <= 1'b1;
      remain_q <= CW'(FETCH_CYCLES - 1);
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (remain_q == '0);
endmodule

// File: rtl/fuse_ar_sel.sv
module fuse_ar_sel
  import fuse_ar_pkg::*;
(
  input  logic [IMG_W-1:0]  image,
  input  logic [IDX_W-1:0]  idx,
  input  logic              priv,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_unpack
    assign words[g] = image[g*WORD_W +: WORD_W];
  end

  assign word = word_visible(idx, priv) ? words[idx[WSEL_W-1:0]] : '0;
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl
  import fuse_ar_pkg::*;
#(
  parameter int FETCH_CYCLES = 8,
  parameter int CLK_MHZ      = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              req_secure,
  input  logic [IMG_W-1:0]  fuse_image,
  output logic              irq
);
  localparam logic [31:0] CMD_MASK = cmd_mask();

  logic [31:0]       cmd_q;
  logic [31:0]       result_q;
  logic              finish;
  logic [IDX_W-1:0]  req_idx_q;
  logic              req_priv_q;
  logic              busy;
  logic              done;
  logic [WORD_W-1:0] picked;

  // Named events for the checker.
  logic wr_cmd, wr_status, clr_req, launch;
  assign wr_cmd    = bus_sel && bus_wr && (bus_addr == OFS_CMD);
  assign wr_status = bus_sel && bus_wr && (bus_addr == OFS_STATUS);
  assign clr_req   = wr_status && bus_wdata[BIT_FIN];
  assign launch    = wr_cmd && !busy && is_launch(bus_wdata);

  fuse_ar_seq #(.FETCH_CYCLES(FETCH_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .busy   (busy),
    .done   (done)
  );

  fuse_ar_sel u_sel (
    .image (fuse_image),
    .idx   (req_idx_q),
    .priv  (req_priv_q),
    .word  (picked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      result_q   <= '0;
      finish     <= 1'b0;
      req_idx_q  <= '0;
      req_priv_q <= 1'b0;
    end else begin
      if (wr_cmd && !busy) cmd_q <= bus_wdata & CMD_MASK;
      else if (done) begin
        cmd_q[BIT_EN] <= 1'b0;
        cmd_q[BIT_RD] <= 1'b0;
      end
      if (launch) begin
        req_idx_q  <= bus_wdata[IDX_LSB +: IDX_W];
        req_priv_q <= req_secure;
      end
      if (done) result_q <= picked;
      if (done) finish <= 1'b1;
      else if (clr_req) finish <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (bus_addr)
        OFS_STATUS: begin
          bus_rdata[BIT_FIN]  = finish;
          bus_rdata[BIT_BUSY] = busy;
        end
        OFS_RESULT: bus_rdata = result_q;
        OFS_CMD:    bus_rdata = cmd_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq = finish;
endmodule

// File: rtl/fuse_ar_chk.sv
module fuse_ar_chk
  import fuse_ar_pkg::*;
#(
  parameter int FETCH_CYCLES = 8,
  parameter int CLK_MHZ      = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             finish,
  input logic             clr_req,
  input logic             wr_cmd,
  input logic [31:0]      cmd_q,
  input logic [31:0]      result_q,
  input logic [IDX_W-1:0] req_idx_q,
  input logic             req_priv_q
);
  localparam int DEADLINE = 4 * CLK_MHZ;

  logic [15:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  AST_DONE_ENDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && finish && (cmd_q[1:0] == 2'b00))); // R4

  AST_FINISH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finish) |-> $past(done)); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !done) |=> !finish); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && done) |=> finish); // R7

  AST_CMD_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy && !done) |=> $stable(cmd_q)); // R8

  AST_PROTECTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_priv_q && (req_idx_q < IDX_W'(SECURE_WORDS))) |=> (result_q == '0)); // R5

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (req_idx_q >= IDX_W'(NUM_WORDS))) |=> (result_q == '0)); // R6

  AST_FETCH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= 16'(FETCH_CYCLES)); // R10

  AST_FETCH_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= 16'(DEADLINE)); // R10
endmodule

bind fuse_autoread_ctrl fuse_ar_chk #(
  .FETCH_CYCLES (FETCH_CYCLES),
  .CLK_MHZ      (CLK_MHZ)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .finish     (finish),
  .clr_req    (clr_req),
  .wr_cmd     (wr_cmd),
  .cmd_q      (cmd_q),
  .result_q   (result_q),
  .req_idx_q  (req_idx_q),
  .req_priv_q (req_priv_q)
);

// File: tb/sim_fuse_autoread_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_autoread_ctrl;
  localparam int FETCH = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         req_secure = 1'b0;
  logic [1023:0] img = '0;
  logic         irq;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  fuse_autoread_ctrl #(.FETCH_CYCLES(FETCH), .CLK_MHZ(200)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_secure(req_secure), .fuse_image(img), .irq(irq)
  );

  function automatic logic [31:0] exp_word(int idx, bit priv);
    if (idx > 31) return 32'h0;
    if (!priv && idx < 24) return 32'h0;
    return img[idx*32 +: 32];
  endfunction

  function automatic logic [31:0] cmd_word(int idx, bit rd, bit en);
    return {6'b0, 10'(idx), 14'b0, rd, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks enter at a falling edge and return at the next one.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_idle(output int cycles);
    logic [31:0] s;
    cycles = 0;
    for (int k = 0; k < 2000; k++) begin
      rd(8'h18, s);
      if (!s[1]) break;
      cycles++;
    end
  endtask

  task automatic run_all();
    logic [31:0] v;
    int bc;
    void'($urandom(32'd4242));
    for (int w = 0; w < 32; w++) img[w*32 +: 32] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h18, v); check("R1 status", v, 0);
    rd(8'h20, v); check("R1 result", v, 0);
    rd(8'h24, v); check("R1 cmd", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R3: half commands
    wr(8'h24, cmd_word(25, 0, 1));
    rd(8'h18, v); check("R3 no busy en-only", v, 0);
    rd(8'h24, v); check("R3 fields stored", v, cmd_word(25, 0, 1));
    wr(8'h24, cmd_word(26, 1, 0));
    repeat (FETCH + 2) @(negedge clk);
    rd(8'h18, v); check("R3 no finish rd-only", v, 0);

    // R2 + R4: privileged fetch of word 30
    req_secure = 1;
    wr(8'h24, cmd_word(30, 1, 1));
    wait_idle(bc);
    check("R2 busy length", bc, FETCH);
    rd(8'h20, v); check("R4 word 30", v, exp_word(30, 1));
    rd(8'h18, v); check("R4 finish set", v, 1);
    rd(8'h24, v); check("R4 cmd bits cleared", v, cmd_word(30, 0, 0));
    check("R9 irq high", {31'b0, irq}, 1);

    // R7: write zero keeps, write one clears
    wr(8'h18, 0);
    rd(8'h18, v); check("R7 zero write keeps", v, 1);
    wr(8'h18, 1);
    rd(8'h18, v); check("R7 one write clears", v, 0);
    check("R9 irq low", {31'b0, irq}, 0);

    // R5: unprivileged access to a protected word, then to an open word
    req_secure = 0;
    wr(8'h24, cmd_word(5, 1, 1));
    wait_idle(bc);
    rd(8'h20, v); check("R5 protected zero", v, 0);
    rd(8'h18, v); check("R5 finish on protected", v, 1);
    wr(8'h18, 1);
    wr(8'h24, cmd_word(24, 1, 1));
    wait_idle(bc);
    rd(8'h20, v); check("R5 open word 24", v, exp_word(24, 0));
    wr(8'h18, 1);
    req_secure = 1;
    wr(8'h24, cmd_word(0, 1, 1));
    wait_idle(bc);
    rd(8'h20, v); check("R5 privileged word 0", v, exp_word(0, 1));
    wr(8'h18, 1);

    // R6: index beyond the array
    wr(8'h24, cmd_word(700, 1, 1));
    wait_idle(bc);
    rd(8'h20, v); check("R6 out of range zero", v, 0);
    rd(8'h18, v); check("R6 finish set", v, 1);
    wr(8'h18, 1);

    // R8: write while busy is ignored
    wr(8'h24, cmd_word(27, 1, 1));
    wr(8'h24, cmd_word(3, 1, 1));
    rd(8'h24, v); check("R8 cmd held", v, cmd_word(27, 1, 1));
    wait_idle(bc);
    check("R8 single fetch length", bc, FETCH - 2);
    rd(8'h20, v); check("R8 first word kept", v, exp_word(27, 1));
    wr(8'h18, 1);
    repeat (FETCH + 2) @(negedge clk);
    rd(8'h18, v); check("R8 no second fetch", v, 0);

    // R7: clear on the completing edge; set wins
    wr(8'h24, cmd_word(31, 1, 1));
    repeat (FETCH - 1) @(negedge clk);
    wr(8'h18, 1);
    rd(8'h18, v); check("R7 set beats clear", v, 1);
    wr(8'h18, 1);

    // R11: unmapped reads, result not writable
    rd(8'h00, v); check("R11 unmapped 0x00", v, 0);
    rd(8'h1C, v); check("R11 unmapped 0x1C", v, 0);
    wr(8'h20, 32'hDEADBEEF);
    rd(8'h20, v); check("R11 result not writable", v, exp_word(31, 1));

    // Random fetches
    for (int it = 0; it < 60; it++) begin
      int idx;
      bit pr;
      idx = int'($urandom_range(0, 40));
      pr  = 1'($urandom_range(0, 1));
      req_secure = pr;
      repeat ($urandom_range(0, 3)) @(negedge clk);
      wr(8'h24, cmd_word(idx, 1, 1));
      req_secure = ~pr;
      wait_idle(bc);
      check("R2 random busy length", bc, FETCH);
      rd(8'h20, v); check("R5 random word", v, exp_word(idx, pr));
      check("R10 irq after fetch", {31'b0, irq}, 1);
      wr(8'h18, 1);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R10 watchdog actual=expired expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule